// File: doc/BRIEF.md
# Lazy Overflow Flag Evaluator

This block keeps the record of the most recent flag-setting operation instead of a finished overflow bit. On each update strobe it stores the operation class, the source, destination and result values, and whether the operation was byte or word sized. The overflow flag is worked out only when it is read, from that stored record. Each operation class has its own rule.

An execution unit pulses the update strobe alongside every instruction that defines overflow. The execute path then needs no overflow logic. A consumer such as a conditional branch or a flag-register push raises a read request and receives the flag one cycle later. The precomputed ("eager") class carries a complete flag word in the result field. This serves paths such as restoring the flag register from memory, where overflow is already known.

Top module: `lazy_ovf_flag`

## Requirements
- R1: After reset the record holds the eager class with a zero flag word, so the first read returns overflow 0. The read-valid output stays low during reset.
- R2: A read request in cycle n produces read-valid high in cycle n+1 with the flag on the overflow output. Read-valid is low in every cycle that follows a cycle without a request.
- R3: Eager class (code 0): overflow equals bit 11 of the stored result word. All 16 result bits are kept whatever the width input says.
- R4: Increment class (code 1): overflow is 1 exactly when the stored result equals the sign-bit mask.
- R5: Decrement class (code 2): overflow is 1 exactly when the stored result equals the sign-bit mask minus one.
- R6: Shift class (code 3): overflow is 1 when the sign bits of the stored destination and result differ.
- R7: Subtract class (code 4): overflow is 1 when the source and destination signs differ and the result sign differs from the destination sign.
- R8: The sign-bit mask is 0x0080 in byte mode (width input 0) and 0x8000 in word mode (width input 1). For every class except eager, byte mode zero-extends the stored operands, so bits 15..8 of the inputs have no effect.
- R9: Class codes 5, 6 and 7 yield overflow 0.
- R10: An update overwrites all stored fields in one clock. A read requested in the same cycle as an update reports the record from before that update. A read in the next cycle reports the new record.
- R11: Without an update strobe the record is held, and repeated reads return the same flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | Update strobe: capture a new operation record |
| upd_cls | input | 3 | Operation class code (0 eager, 1 inc, 2 dec, 3 shift, 4 sub) |
| upd_src | input | 16 | Source operand value |
| upd_dst | input | 16 | Destination operand value before the operation |
| upd_res | input | 16 | Result value, or the full flag word for the eager class |
| upd_word | input | 1 | Operand width: 1 word, 0 byte |
| rd_req | input | 1 | Request the overflow flag |
| rd_valid | output | 1 | Overflow output valid, one cycle after the request |
| rd_ovf | output | 1 | Lazily evaluated overflow flag |

## Verification
Recording and evaluating can fall in the same cycle when an update strobe and a read request are raised together. The bench provokes this by storing a record that overflows and then, in one cycle, strobing a non-overflowing record while requesting a read. It judges the result by expecting the old flag on that read and the new flag on the read that follows. Its scoreboard model fixes the expected value at the moment the request is issued and applies the update afterwards, so an evaluator that reads the incoming values instead of the stored record is caught.

// File: rtl/lof_pkg.sv
package lof_pkg;

  // Operation class codes; codes above LOF_CLS_LAST are spare
  localparam int unsigned LOF_CLS_W    = 3;
  localparam logic [2:0]  LOF_EAGER    = 3'd0;
  localparam logic [2:0]  LOF_INC      = 3'd1;
  localparam logic [2:0]  LOF_DEC      = 3'd2;
  localparam logic [2:0]  LOF_SHIFT    = 3'd3;
  localparam logic [2:0]  LOF_SUB      = 3'd4;
  localparam logic [2:0]  LOF_CLS_LAST = 3'd4;

  // Default geometry
  localparam int unsigned LOF_DATA_W   = 16;
  localparam int unsigned LOF_NARROW_W = 8;
  localparam int unsigned LOF_OF_POS   = 11;

endpackage

// File: rtl/lof_rst_sync.sv
module lof_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/lof_capture.sv
module lof_capture
  import lof_pkg::*;
#(
  parameter int unsigned DW = LOF_DATA_W,
  parameter int unsigned NW = LOF_NARROW_W
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 upd_valid,
  input  logic [LOF_CLS_W-1:0] upd_cls,
  input  logic [DW-1:0]        upd_src,
  input  logic [DW-1:0]        upd_dst,
  input  logic [DW-1:0]        upd_res,
  input  logic                 upd_word,
  output logic [LOF_CLS_W-1:0] sav_cls,
  output logic [DW-1:0]        sav_src,
  output logic [DW-1:0]        sav_dst,
  output logic [DW-1:0]        sav_res,
  output logic                 sav_word
);

  localparam logic [DW-1:0] NARROW_KEEP = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] WIDE_KEEP   = {DW{1'b1}};

  logic [LOF_CLS_W-1:0] cls_d;
  logic [DW-1:0]        src_d;
  logic [DW-1:0]        dst_d;
  logic [DW-1:0]        res_d;
  logic                 word_d;
  logic [DW-1:0]        keep_mask;
  logic                 narrow_op;

  // Byte operations are zero-extended on capture; an eager flag word stays whole
  always_comb begin
    narrow_op = (upd_cls != LOF_EAGER) && !upd_word;
    keep_mask = narrow_op ? NARROW_KEEP : WIDE_KEEP;
    cls_d     = upd_cls;
    src_d     = upd_src & keep_mask;
    dst_d     = upd_dst & keep_mask;
    res_d     = upd_res & keep_mask;
    word_d    = upd_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sav_cls  <= LOF_EAGER;
      sav_src  <= '0;
      sav_dst  <= '0;
      sav_res  <= '0;
      sav_word <= 1'b1;
    end else if (upd_valid) begin
      sav_cls  <= cls_d;
      sav_src  <= src_d;
      sav_dst  <= dst_d;
      sav_res  <= res_d;
      sav_word <= word_d;
    end
  end

endmodule

// File: rtl/lof_eval.sv
module lof_eval
  import lof_pkg::*;
#(
  parameter int unsigned DW  = LOF_DATA_W,
  parameter int unsigned NW  = LOF_NARROW_W,
  parameter int unsigned OFP = LOF_OF_POS
) (
  input  logic [LOF_CLS_W-1:0] cls,
  input  logic [DW-1:0]        src,
  input  logic [DW-1:0]        dst,
  input  logic [DW-1:0]        res,
  input  logic                 word,
  output logic                 ovf
);

  localparam logic [DW-1:0] WIDE_MSB   = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] NARROW_MSB = {{(DW-NW){1'b0}}, 1'b1, {(NW-1){1'b0}}};

  logic [DW-1:0] sign_mask;
  logic          dst_res_flip;
  logic          src_dst_flip;
  logic          hit_inc;
  logic          hit_dec;

  always_comb begin
    sign_mask    = word ? WIDE_MSB : NARROW_MSB;
    dst_res_flip = |(sign_mask & (dst ^ res));
    src_dst_flip = |(sign_mask & (src ^ dst));
    hit_inc      = (res == sign_mask);
    hit_dec      = (res == (sign_mask - 1'b1));
  end

  always_comb begin
    unique case (cls)
      LOF_EAGER: ovf = res[OFP];
      LOF_INC:   ovf = hit_inc;
      LOF_DEC:   ovf = hit_dec;
      LOF_SHIFT: ovf = dst_res_flip;
      LOF_SUB:   ovf = src_dst_flip & dst_res_flip;
      default:   ovf = 1'b0;
    endcase
  end

endmodule

// File: rtl/lof_read.sv
module lof_read (
  input  logic clk,
  input  logic rst_ni,
  input  logic rd_req,
  input  logic ovf_eval,
  output logic rd_valid,
  output logic rd_ovf
);

  logic valid_d;
  logic ovf_d;

  always_comb begin
    valid_d = rd_req;
    ovf_d   = ovf_eval;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ovf <= 1'b0;
    end else if (rd_req) begin
      rd_ovf <= ovf_d;
    end
  end

endmodule

// File: rtl/lazy_ovf_flag.sv
module lazy_ovf_flag
  import lof_pkg::*;
#(
  parameter int unsigned DATA_W     = LOF_DATA_W,
  parameter int unsigned NARROW_W   = LOF_NARROW_W,
  parameter int unsigned OF_POS     = LOF_OF_POS,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [LOF_CLS_W-1:0] upd_cls,
  input  logic [DATA_W-1:0]    upd_src,
  input  logic [DATA_W-1:0]    upd_dst,
  input  logic [DATA_W-1:0]    upd_res,
  input  logic                 upd_word,
  input  logic                 rd_req,
  output logic                 rd_valid,
  output logic                 rd_ovf
);

  logic                 rst_sync_n;
  logic [LOF_CLS_W-1:0] sav_cls;
  logic [DATA_W-1:0]    sav_src;
  logic [DATA_W-1:0]    sav_dst;
  logic [DATA_W-1:0]    sav_res;
  logic                 sav_word;
  logic                 ovf_eval;

  lof_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  lof_capture #(.DW(DATA_W), .NW(NARROW_W)) u_cap (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .upd_valid (upd_valid),
    .upd_cls   (upd_cls),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_res   (upd_res),
    .upd_word  (upd_word),
    .sav_cls   (sav_cls),
    .sav_src   (sav_src),
    .sav_dst   (sav_dst),
    .sav_res   (sav_res),
    .sav_word  (sav_word)
  );

  lof_eval #(.DW(DATA_W), .NW(NARROW_W), .OFP(OF_POS)) u_eval (
    .cls  (sav_cls),
    .src  (sav_src),
    .dst  (sav_dst),
    .res  (sav_res),
    .word (sav_word),
    .ovf  (ovf_eval)
  );

  lof_read u_rd (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .rd_req   (rd_req),
    .ovf_eval (ovf_eval),
    .rd_valid (rd_valid),
    .rd_ovf   (rd_ovf)
  );

endmodule

// File: rtl/lazy_ovf_flag_chk.sv
module lazy_ovf_flag_chk
  import lof_pkg::*;
#(
  parameter int unsigned DW = LOF_DATA_W,
  parameter int unsigned NW = LOF_NARROW_W
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 upd_valid,
  input logic [LOF_CLS_W-1:0] upd_cls,
  input logic                 rd_req,
  input logic                 rd_valid,
  input logic                 rd_ovf,
  input logic [LOF_CLS_W-1:0] sav_cls,
  input logic [DW-1:0]        sav_res,
  input logic                 sav_word
);

  localparam logic [DW-1:0] WIDE_MSB   = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] NARROW_MSB = {{(DW-NW){1'b0}}, 1'b1, {(NW-1){1'b0}}};

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_req |=> rd_valid); // R2

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_req |=> !rd_valid); // R2

  AST_CLASS_CAPTURED: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_valid |=> (sav_cls == $past(upd_cls))); // R10

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_valid |=> ($stable(sav_cls) && $stable(sav_res) && $stable(sav_word))); // R11

  AST_SPARE_CLASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && ($past(sav_cls) > LOF_CLS_LAST)) |-> !rd_ovf); // R9

  AST_INC_RULE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && ($past(sav_cls) == LOF_INC)) |->
      (rd_ovf == ($past(sav_res) == ($past(sav_word) ? WIDE_MSB : NARROW_MSB)))); // R4

endmodule

bind lazy_ovf_flag lazy_ovf_flag_chk #(.DW(DATA_W), .NW(NARROW_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .upd_valid (upd_valid),
  .upd_cls   (upd_cls),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_ovf    (rd_ovf),
  .sav_cls   (sav_cls),
  .sav_res   (sav_res),
  .sav_word  (sav_word)
);

// File: tb/lazy_ovf_flag_test.sv
`timescale 1ns/1ps
module lazy_ovf_flag_test;

  typedef struct packed {
    logic exp;
    int   tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        upd_valid;
  logic [2:0]  upd_cls;
  logic [15:0] upd_src;
  logic [15:0] upd_dst;
  logic [15:0] upd_res;
  logic        upd_word;
  logic        rd_req;
  logic        rd_valid;
  logic        rd_ovf;

  int    n_checks;
  int    n_errors;
  bit    finished;
  item_t sb_q[$];

  // Reference record
  logic [2:0]  m_cls;
  logic [15:0] m_src;
  logic [15:0] m_dst;
  logic [15:0] m_res;
  logic        m_word;

  lazy_ovf_flag uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_cls   (upd_cls),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_res   (upd_res),
    .upd_word  (upd_word),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_ovf    (rd_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic model_ovf();
    int          sb;
    logic [15:0] lim;
    sb  = m_word ? 15 : 7;
    lim = 16'(1) << sb;
    case (m_cls)
      3'd0:    return m_res[11];
      3'd1:    return m_res == lim;
      3'd2:    return m_res == lim - 16'd1;
      3'd3:    return m_dst[sb] != m_res[sb];
      3'd4:    return (m_src[sb] != m_dst[sb]) && (m_res[sb] != m_dst[sb]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic report(input string summary);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    if (summary.len() != 0) $display("%s", summary);
  endtask

  // Driver: one cycle of stimulus; a read pushes the expectation taken before the update
  task automatic step(input logic uv, input logic [2:0] c, input logic [15:0] s,
                      input logic [15:0] d, input logic [15:0] r, input logic w,
                      input logic rd, input int tag);
    @(negedge clk);
    upd_valid = uv;
    upd_cls   = c;
    upd_src   = s;
    upd_dst   = d;
    upd_res   = r;
    upd_word  = w;
    rd_req    = rd;
    if (rd) sb_q.push_back('{exp: model_ovf(), tag: tag});
    if (uv) begin
      m_cls  = c;
      m_word = w;
      if (c != 3'd0 && !w) begin
        m_src = {8'h00, s[7:0]};
        m_dst = {8'h00, d[7:0]};
        m_res = {8'h00, r[7:0]};
      end else begin
        m_src = s;
        m_dst = d;
        m_res = r;
      end
    end
  endtask

  task automatic load_read(input logic [2:0] c, input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] r, input logic w, input int tag);
    step(1'b1, c, s, d, r, w, 1'b0, tag);
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, tag);
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_errors++;
        $display("FAIL R2: rd_valid=1 without request (actual 1, expected 0)");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rd_ovf !== it.exp) begin
          n_errors++;
          $display("FAIL R%0d: rd_ovf actual %b expected %b", it.tag, rd_ovf, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: run hung (actual running, expected done)");
      report("");
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; finished = 0;
    rst_n = 1'b0; upd_valid = 1'b0; upd_cls = 3'd0; upd_src = '0; upd_dst = '0;
    upd_res = '0; upd_word = 1'b0; rd_req = 1'b0;
    m_cls = 3'd0; m_src = '0; m_dst = '0; m_res = '0; m_word = 1'b1;
    repeat (3) @(negedge clk);
    // R1: read-valid low during reset
    n_checks++;
    if (rd_valid !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: rd_valid in reset actual %b expected 0", rd_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset record reads as no overflow
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 1);

    // R3: eager class takes bit 11, full word kept even in byte mode
    load_read(3'd0, 16'h0, 16'h0, 16'h0800, 1'b1, 3);
    load_read(3'd0, 16'h0, 16'h0, 16'hF7FF, 1'b1, 3);
    load_read(3'd0, 16'h0, 16'h0, 16'h0800, 1'b0, 3);

    // R4: increment
    load_read(3'd1, 16'h0, 16'h7FFF, 16'h8000, 1'b1, 4);
    load_read(3'd1, 16'h0, 16'h8000, 16'h8001, 1'b1, 4);
    load_read(3'd1, 16'h0, 16'h007F, 16'h0080, 1'b0, 4);
    // R8: upper byte ignored in byte mode
    load_read(3'd1, 16'h0, 16'hAB7F, 16'h1280, 1'b0, 8);
    load_read(3'd1, 16'h0, 16'h0, 16'h0080, 1'b1, 8);

    // R5: decrement
    load_read(3'd2, 16'h0, 16'h8000, 16'h7FFF, 1'b1, 5);
    load_read(3'd2, 16'h0, 16'h0080, 16'h007F, 1'b0, 5);
    load_read(3'd2, 16'h0, 16'h0080, 16'hFF7F, 1'b0, 8);
    load_read(3'd2, 16'h0, 16'h0080, 16'h007F, 1'b1, 8);

    // R6: shift
    load_read(3'd3, 16'h1, 16'h4000, 16'h8000, 1'b1, 6);
    load_read(3'd3, 16'h1, 16'h8000, 16'hC000, 1'b1, 6);
    load_read(3'd3, 16'h1, 16'h0040, 16'h0080, 1'b0, 6);
    load_read(3'd3, 16'h1, 16'h8040, 16'h0040, 1'b0, 8);

    // R7: subtract
    load_read(3'd4, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 7);
    load_read(3'd4, 16'h0003, 16'h0005, 16'h0002, 1'b1, 7);
    load_read(3'd4, 16'hFFFF, 16'h7FFF, 16'h8000, 1'b1, 7);
    load_read(3'd4, 16'h0001, 16'h0080, 16'h007F, 1'b0, 7);
    load_read(3'd4, 16'hFF01, 16'h0080, 16'hFF7F, 1'b0, 8);

    // R9: spare class codes never flag
    load_read(3'd5, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 9);
    load_read(3'd6, 16'h0800, 16'h4000, 16'h8000, 1'b1, 9);
    load_read(3'd7, 16'h0000, 16'h0000, 16'h8800, 1'b1, 9);

    // R10: update and read in one cycle -> old record, then new record
    step(1'b1, 3'd1, 16'h0, 16'h7FFF, 16'h8000, 1'b1, 1'b0, 10);
    step(1'b1, 3'd4, 16'h0003, 16'h0005, 16'h0002, 1'b1, 1'b1, 10);
    step(1'b1, 3'd2, 16'h0, 16'h8000, 16'h7FFF, 1'b1, 1'b1, 10);
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 10);

    // R11: record held over idle cycles with changing inputs, reads repeat
    step(1'b0, 3'd4, 16'hFFFF, 16'h0000, 16'h1234, 1'b0, 1'b1, 11);
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 11);
    step(1'b0, 3'd3, 16'h0000, 16'h8000, 16'h0000, 1'b1, 1'b0, 11);
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 11);
    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 11);

    step(1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2);
    repeat (3) @(negedge clk);
    // R2: every request answered
    n_checks++;
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL R2: unanswered reads actual %0d expected 0", sb_q.size());
    end
    finished = 1;
    report("");
    $finish;
  end

endmodule